// File: doc/BRIEF.md
# Parallel Camera Capture Front End

This block takes the parallel output of an image sensor (a pixel clock, an 8-bit data bus, and vertical sync, horizontal sync and horizontal blank strobes) and turns it into 32-bit words that software reads through a register bus. All sensor inputs are sampled in the system clock domain. A pixel byte is taken on the configured edge of the sampled pixel clock, but only after the first active vertical-sync edge, only while horizontal sync is active, and only while horizontal blank is inactive. The active level of each of the three strobes can be set independently.

Four accepted bytes form one word, and each word goes into a 16-entry FIFO. Software drains the FIFO through a read window that returns either a whole word or one byte per access. One control/status register holds the configuration, the FIFO-valid status, a sticky overwrite flag, and two interrupt flags: a half-full FIFO flag and a sync flag whose source can be set. Flags are cleared by writing 0 to them. Each flag has a mask, and the interrupt output is the OR of the enabled flags. Two self-clearing command bits let software empty the FIFO or put the capture logic back to idle. The frame-size code is stored and turned into the expected pixel count per line.

Top module: `cam_capture_top`

## Requirements
- R1: After reset the control/status register (bus address 0) reads 0, the interrupt output is low and the FIFO is empty.
- R2: No byte is captured before the first active vertical-sync edge after reset or soft reset. After that, bytes are captured only while horizontal sync is active and horizontal blank is inactive.
- R3: Polarity bits 1 (vertical sync), 2 (horizontal sync) and 3 (horizontal blank) select the active level of each strobe: 0 means active-low, 1 means active-high.
- R4: Bit 0 selects the capture edge of the pixel clock: 0 captures on the rising edge, 1 on the falling edge.
- R5: Each group of four captured bytes forms one word, with the first byte in bits [7:0] and the fourth in bits [31:24]. When bit 5 is 0, a read of the window (bus address 1) returns the oldest word and removes it.
- R6: When bit 5 is 1, each window read returns one byte of the oldest word in bits [7:0], in arrival order, with the upper bits 0. The word is removed after its fourth byte has been read.
- R7: Status bit 16 reads 1 exactly when the FIFO holds a word. A window read while the FIFO is empty returns 0.
- R8: The FIFO holds 16 words. A word completed while the FIFO is full is dropped and sets flag bit 17. Writing 0 to bit 17 clears the flag; writing 1 leaves it unchanged.
- R9: Flag bit 18 is set when the FIFO level reaches 8 words. It is cleared by writing 0 and unaffected by writing 1.
- R10: Flag bit 19 is set on an active edge of vertical sync when bit 4 is 0, or on an active edge of horizontal blank when bit 4 is 1. It is cleared by writing 0 and unaffected by writing 1.
- R11: The interrupt output equals (bit 18 AND mask bit 6) OR (bit 19 AND mask bit 7).
- R12: Writing 1 to bit 24 empties the FIFO. Bit 24 always reads 0.
- R13: Writing 1 to bit 25 clears all flags, empties the FIFO, and disarms capture until the next active vertical-sync edge. Configuration bits [11:0] take the written value, and bit 25 always reads 0.
- R14: Output `line_px` gives the pixel count per line for frame-size code bits [11:8]: 0→160, 1→320, 2→320, 3→640, 5→1280, 6→1280, 7→176, 8→352, and any other code→0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_pclk | input | 1 | Sensor pixel clock, sampled by clk |
| cam_vsync | input | 1 | Vertical sync strobe |
| cam_hsync | input | 1 | Horizontal sync strobe |
| cam_hblank | input | 1 | Horizontal blank strobe |
| cam_data | input | 8 | Pixel data byte |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a window read removes data) |
| bus_addr | input | 2 | Word address: 0 control/status, 1 FIFO window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Combined interrupt |
| line_px | output | 11 | Expected pixels per line for the frame-size code |

## Verification
Pixel bytes are driven with the strobes in each combination of active and inactive: before any vertical sync, with horizontal sync inactive, during blanking, and in an open line. This shows that every gating term blocks capture on its own. On the return edge of each byte the data bus is inverted, so a word captured on the wrong pixel-clock edge reads back with changed bits. This is repeated with all polarities set to active-high and the falling edge selected. A 17-word burst shows where the half-full flag and the overwrite flag each switch on, and shows that the dropped word does not displace the stored ones. The same data is read in word and byte window modes to tell apart packing order from read order.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

  // control/status register bit positions
  localparam int B_EDGE    = 0;
  localparam int B_VSPOL   = 1;
  localparam int B_HSPOL   = 2;
  localparam int B_HBPOL   = 3;
  localparam int B_SYNCSRC = 4;
  localparam int B_WINBYTE = 5;
  localparam int B_FMASK   = 6;
  localparam int B_SMASK   = 7;
  localparam int B_FSIZE   = 8;
  localparam int CFG_W     = 12;
  localparam int B_VALID   = 16;
  localparam int B_OVW     = 17;
  localparam int B_FFLAG   = 18;
  localparam int B_SFLAG   = 19;
  localparam int B_PCLR    = 24;
  localparam int B_SRST    = 25;

  typedef struct packed {
    logic edge_fall;
    logic vs_high;
    logic hs_high;
    logic hb_high;
  } cam_pol_t;

  typedef struct packed {
    logic pclk;
    logic vs;
    logic hs;
    logic hb;
  } cam_strobe_t;

  function automatic logic [10:0] frame_line_px(input logic [3:0] code);
    logic [10:0] px;
    case (code)
      4'd0:    px = 11'd160;
      4'd1:    px = 11'd320;
      4'd2:    px = 11'd320;
      4'd3:    px = 11'd640;
      4'd5:    px = 11'd1280;
      4'd6:    px = 11'd1280;
      4'd7:    px = 11'd176;
      4'd8:    px = 11'd352;
      default: px = 11'd0;
    endcase
    return px;
  endfunction

endpackage

// File: rtl/cam_sync_front.sv
module cam_sync_front
  import cam_cap_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  cam_pol_t          pol,
  input  logic              pclk,
  input  logic              vsync,
  input  logic              hsync,
  input  logic              hblank,
  input  logic [BYTE_W-1:0] data,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data,
  output logic              vs_rise,
  output logic              hb_rise,
  output logic              armed
);

  cam_strobe_t       smp_q, prev_q;
  logic [BYTE_W-1:0] dat_q;
  logic              armed_q, armed_d;
  logic              vs_act, hs_act, hb_act, vs_act_p, hb_act_p, pclk_edge;

  // active levels computed with the current polarity for both samples,
  // so a polarity change never looks like an edge
  always_comb begin
    vs_act    = pol.vs_high ? smp_q.vs  : ~smp_q.vs;
    hs_act    = pol.hs_high ? smp_q.hs  : ~smp_q.hs;
    hb_act    = pol.hb_high ? smp_q.hb  : ~smp_q.hb;
    vs_act_p  = pol.vs_high ? prev_q.vs : ~prev_q.vs;
    hb_act_p  = pol.hb_high ? prev_q.hb : ~prev_q.hb;
    pclk_edge = pol.edge_fall ? (prev_q.pclk & ~smp_q.pclk)
                              : (~prev_q.pclk & smp_q.pclk);
    vs_rise   = vs_act & ~vs_act_p;
    hb_rise   = hb_act & ~hb_act_p;
  end

  always_comb begin
    armed_d = armed_q;
    if (clr)          armed_d = 1'b0;
    else if (vs_rise) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q   <= '0;
      prev_q  <= '0;
      dat_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      smp_q   <= '{pclk: pclk, vs: vsync, hs: hsync, hb: hblank};
      prev_q  <= smp_q;
      dat_q   <= data;
      armed_q <= armed_d;
    end
  end

  assign byte_vld  = armed_q & pclk_edge & hs_act & ~hb_act & ~clr;
  assign byte_data = dat_q;
  assign armed     = armed_q;

  // R13: a soft reset leaves capture disarmed
  assert_swrst_disarms_R13: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !armed_q);

  // R2: capture never starts without a vertical-sync edge while idle
  assert_arm_needs_vsync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(vs_rise));

endmodule

// File: rtl/cam_packer.sv
module cam_packer #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    byte_vld,
  input  logic [BYTE_W-1:0]       byte_data,
  output logic                    word_vld,
  output logic [LANES*BYTE_W-1:0] word
);

  localparam int CW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANES*BYTE_W-1:0] acc_q, acc_d;
  logic [CW-1:0]           cnt_q, cnt_d;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic hit;
    assign hit = (cnt_q == CW'(l));
    assign word[l*BYTE_W +: BYTE_W]  = hit ? byte_data : acc_q[l*BYTE_W +: BYTE_W];
    assign acc_d[l*BYTE_W +: BYTE_W] = (byte_vld && hit) ? byte_data
                                                         : acc_q[l*BYTE_W +: BYTE_W];
  end

  assign word_vld = byte_vld && (cnt_q == CW'(LANES-1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)           cnt_d = '0;
    else if (word_vld) cnt_d = '0;
    else if (byte_vld) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  // R5: lane counter never exceeds the last lane
  assert_lane_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LANES-1));

endmodule

// File: rtl/cam_fifo.sv
module cam_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     push,
  input  logic [W-1:0]             wdata,
  input  logic                     pop,
  output logic [W-1:0]             head,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     full,
  output logic                     empty
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  assign full    = (lvl_q == LW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = push & ~full & ~clr;
  assign do_pop  = pop & ~empty & ~clr;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      lvl_d  = '0;
    end else begin
      if (do_push) wptr_d = wptr_q + AW'(1);
      if (do_pop)  rptr_d = rptr_q + AW'(1);
      lvl_d = lvl_q + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata;
  end

  assign head  = mem[rptr_q];
  assign level = lvl_q;

  // R8: the level never passes the depth
  assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(DEPTH));

  // R8: a push into a full FIFO without a pop leaves it full, not wrapped
  assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> full);

endmodule

// File: rtl/cam_regs.sv
module cam_regs
  import cam_cap_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [LANES*BYTE_W-1:0]   bus_wdata,
  output logic [LANES*BYTE_W-1:0]   bus_rdata,
  input  logic [LANES*BYTE_W-1:0]   fifo_head,
  input  logic [$clog2(DEPTH):0]    fifo_level,
  input  logic                      fifo_full,
  input  logic                      fifo_empty,
  input  logic                      word_vld,
  input  logic                      vs_rise,
  input  logic                      hb_rise,
  output logic                      fifo_pop,
  output logic                      fifo_clr,
  output logic                      soft_rst,
  output cam_pol_t                  pol,
  output logic                      irq,
  output logic [10:0]               line_px
);

  localparam int BUS_W = LANES * BYTE_W;
  localparam int IW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int LW    = $clog2(DEPTH) + 1;
  localparam int HALF  = DEPTH / 2;

  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             ovw_q, ovw_d, fflag_q, fflag_d, sflag_q, sflag_d;
  logic             ge_q, ge_now;
  logic [IW-1:0]    idx_q, idx_d;
  logic             ctrl_wr, win_rd, ptr_clr, sync_evt, ff_evt, win_byte;

  assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(0));
  assign soft_rst = ctrl_wr && bus_wdata[B_SRST];
  assign ptr_clr  = ctrl_wr && bus_wdata[B_PCLR];
  assign fifo_clr = soft_rst | ptr_clr;
  assign win_byte = cfg_q[B_WINBYTE];
  assign win_rd   = bus_rd && (bus_addr == ADDR_W'(1)) && !fifo_empty;
  assign fifo_pop = win_rd && (!win_byte || (idx_q == IW'(LANES-1)));
  assign ge_now   = (fifo_level >= LW'(HALF));
  assign ff_evt   = ge_now && !ge_q;
  assign sync_evt = cfg_q[B_SYNCSRC] ? hb_rise : vs_rise;

  always_comb begin
    cfg_d   = ctrl_wr ? bus_wdata[CFG_W-1:0] : cfg_q;

    ovw_d   = ovw_q;
    fflag_d = fflag_q;
    sflag_d = sflag_q;
    if (soft_rst) begin
      ovw_d   = 1'b0;
      fflag_d = 1'b0;
      sflag_d = 1'b0;
    end else begin
      if (word_vld && fifo_full)              ovw_d = 1'b1;
      else if (ctrl_wr && !bus_wdata[B_OVW])  ovw_d = 1'b0;
      if (ff_evt)                             fflag_d = 1'b1;
      else if (ctrl_wr && !bus_wdata[B_FFLAG]) fflag_d = 1'b0;
      if (sync_evt)                           sflag_d = 1'b1;
      else if (ctrl_wr && !bus_wdata[B_SFLAG]) sflag_d = 1'b0;
    end

    idx_d = idx_q;
    if (fifo_clr)                idx_d = '0;
    else if (win_rd && win_byte) idx_d = idx_q + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      ovw_q   <= 1'b0;
      fflag_q <= 1'b0;
      sflag_q <= 1'b0;
      ge_q    <= 1'b0;
      idx_q   <= '0;
    end else begin
      cfg_q   <= cfg_d;
      ovw_q   <= ovw_d;
      fflag_q <= fflag_d;
      sflag_q <= sflag_d;
      ge_q    <= ge_now;
      idx_q   <= idx_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(0)) begin
      bus_rdata[CFG_W-1:0] = cfg_q;
      bus_rdata[B_VALID]   = !fifo_empty;
      bus_rdata[B_OVW]     = ovw_q;
      bus_rdata[B_FFLAG]   = fflag_q;
      bus_rdata[B_SFLAG]   = sflag_q;
    end else if (bus_addr == ADDR_W'(1) && !fifo_empty) begin
      if (win_byte) bus_rdata[BYTE_W-1:0] = fifo_head[idx_q*BYTE_W +: BYTE_W];
      else          bus_rdata             = fifo_head;
    end
  end

  assign pol = '{edge_fall: cfg_q[B_EDGE], vs_high: cfg_q[B_VSPOL],
                 hs_high:   cfg_q[B_HSPOL], hb_high: cfg_q[B_HBPOL]};
  assign irq = (fflag_q & cfg_q[B_FMASK]) | (sflag_q & cfg_q[B_SMASK]);
  assign line_px = frame_line_px(cfg_q[B_FSIZE +: 4]);

  // R12: a pointer clear leaves the FIFO empty
  assert_ptr_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> fifo_empty);

  // R8: the overwrite flag only rises after a word met a full FIFO
  assert_ovw_on_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovw_q) |-> $past(fifo_full));

  // R9: the half flag only rises once the level has reached half
  assert_half_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fflag_q) |-> ($past(fifo_level) >= LW'(HALF)));

  // R11: with both masks clear the interrupt stays low
  assert_masked_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[B_FMASK] && !cfg_q[B_SMASK]) |-> !irq);

  // R13: soft reset clears every flag
  assert_swrst_flags_R13: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!ovw_q && !fflag_q && !sflag_q));

endmodule

// File: rtl/cam_capture_top.sv
module cam_capture_top
  import cam_cap_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cam_pclk,
  input  logic                    cam_vsync,
  input  logic                    cam_hsync,
  input  logic                    cam_hblank,
  input  logic [BYTE_W-1:0]       cam_data,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [LANES*BYTE_W-1:0] bus_wdata,
  output logic [LANES*BYTE_W-1:0] bus_rdata,
  output logic                    irq,
  output logic [10:0]             line_px
);

  localparam int WORD_W = LANES * BYTE_W;
  localparam int LW     = $clog2(DEPTH) + 1;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              byte_vld, word_vld, vs_rise, hb_rise, armed;
  logic [BYTE_W-1:0] byte_data;
  logic [WORD_W-1:0] word, fifo_head;
  logic [LW-1:0]     fifo_level;
  logic              fifo_full, fifo_empty, fifo_pop, fifo_clr, soft_rst;
  cam_pol_t          pol;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cam_sync_front #(.BYTE_W(BYTE_W)) u_front (
    .clk(clk), .rst_n(rst_int_n), .clr(soft_rst), .pol(pol),
    .pclk(cam_pclk), .vsync(cam_vsync), .hsync(cam_hsync), .hblank(cam_hblank),
    .data(cam_data), .byte_vld(byte_vld), .byte_data(byte_data),
    .vs_rise(vs_rise), .hb_rise(hb_rise), .armed(armed)
  );

  cam_packer #(.BYTE_W(BYTE_W), .LANES(LANES)) u_pack (
    .clk(clk), .rst_n(rst_int_n), .clr(soft_rst),
    .byte_vld(byte_vld), .byte_data(byte_data),
    .word_vld(word_vld), .word(word)
  );

  cam_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_int_n), .clr(fifo_clr),
    .push(word_vld), .wdata(word), .pop(fifo_pop),
    .head(fifo_head), .level(fifo_level), .full(fifo_full), .empty(fifo_empty)
  );

  cam_regs #(.BYTE_W(BYTE_W), .LANES(LANES), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fifo_head(fifo_head), .fifo_level(fifo_level), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .word_vld(word_vld),
    .vs_rise(vs_rise), .hb_rise(hb_rise),
    .fifo_pop(fifo_pop), .fifo_clr(fifo_clr), .soft_rst(soft_rst),
    .pol(pol), .irq(irq), .line_px(line_px)
  );

  // R2: no word is completed while capture is disarmed
  assert_no_word_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    word_vld |-> armed);

endmodule

// File: tb/test_cam_capture_top.sv
module test_cam_capture_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cam_pclk, cam_vsync, cam_hsync, cam_hblank;
  logic [7:0]  cam_data;
  logic        bus_wr, bus_rd;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;
  logic [10:0] line_px;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // bench copy of configuration bits [11:0]
  logic [11:0] cfg = '0;
  localparam logic [31:0] KEEP = 32'h000E_0000;  // bits 17..19 written as 1

  always #5 clk = ~clk;

  cam_capture_top i_cam_capture_top (
    .clk(clk), .rst_n(rst_n), .cam_pclk(cam_pclk), .cam_vsync(cam_vsync),
    .cam_hsync(cam_hsync), .cam_hblank(cam_hblank), .cam_data(cam_data),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .line_px(line_px)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic apply_cfg();
    bus_write(2'd0, KEEP | {20'd0, cfg});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    cam_data = b;
    cam_pclk = cfg[0];
    idle(2);
    cam_pclk = ~cfg[0];
    idle(2);
    cam_data = ~b;
    cam_pclk = cfg[0];
    idle(2);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 0; i < 4; i++) send_byte(w[8*i +: 8]);
  endtask

  task automatic line_on();  cam_hsync = cfg[2];  idle(2); endtask
  task automatic line_off(); cam_hsync = ~cfg[2]; idle(2); endtask
  task automatic blank_on(); cam_hblank = cfg[3];  idle(3); endtask
  task automatic blank_off(); cam_hblank = ~cfg[3]; idle(3); endtask
  task automatic vs_pulse();
    cam_vsync = cfg[1];  idle(3);
    cam_vsync = ~cfg[1]; idle(3);
  endtask

  function automatic logic [31:0] ow(input int i);
    return {8'(i), 8'hC3, 8'(i * 3), 8'h5A};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    bus_read(2'd0, d);
    check("R1 reset status", d, 32'h0);
    check("R1 reset irq", {31'd0, irq}, 32'd0);
    check("R14 reset line_px", {21'd0, line_px}, 32'd160);
  endtask

  task automatic t_gating();
    logic [31:0] d;
    line_on();
    send_word(32'h1122_3344);
    bus_read(2'd0, d);
    check("R2 no capture before vsync", {31'd0, d[16]}, 32'd0);
    vs_pulse();
    bus_read(2'd0, d);
    check("R10 vsync sets sync flag", {31'd0, d[19]}, 32'd1);
    bus_write(2'd0, 32'h0006_0000 | {20'd0, cfg});
    bus_read(2'd0, d);
    check("R10 write 0 clears sync flag", {31'd0, d[19]}, 32'd0);
    line_off();
    send_word(32'h5566_7788);
    bus_read(2'd0, d);
    check("R2 no capture with hsync inactive", {31'd0, d[16]}, 32'd0);
    line_on();
    blank_on();
    send_word(32'h99AA_BBCC);
    bus_read(2'd0, d);
    check("R2 no capture during blank", {31'd0, d[16]}, 32'd0);
    blank_off();
    send_word(32'hA1B2_C3D4);
    bus_read(2'd0, d);
    check("R7 valid set with data", {31'd0, d[16]}, 32'd1);
    bus_read(2'd1, d);
    check("R5 word packing", d, 32'hA1B2_C3D4);
    bus_read(2'd0, d);
    check("R7 valid clear after read", {31'd0, d[16]}, 32'd0);
    bus_read(2'd1, d);
    check("R7 empty window reads 0", d, 32'h0);
  endtask

  task automatic t_bytemode();
    logic [31:0] d;
    logic [63:0] exp;
    exp = 64'h0FED_CBA9_8765_4321;
    cfg[5] = 1'b1; apply_cfg();
    send_word(exp[31:0]);
    send_word(exp[63:32]);
    for (int i = 0; i < 8; i++) begin
      bus_read(2'd1, d);
      check("R6 byte window order", d, {24'd0, exp[8*i +: 8]});
    end
    bus_read(2'd0, d);
    check("R7 valid clear after byte reads", {31'd0, d[16]}, 32'd0);
    cfg[5] = 1'b0; apply_cfg();
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    cfg[6] = 1'b1; apply_cfg();
    for (int i = 0; i < 7; i++) send_word(ow(i));
    bus_read(2'd0, d);
    check("R9 no half flag at 7", {31'd0, d[18]}, 32'd0);
    check("R11 irq low at 7", {31'd0, irq}, 32'd0);
    send_word(ow(7));
    bus_read(2'd0, d);
    check("R9 half flag at 8", {31'd0, d[18]}, 32'd1);
    check("R11 irq on fifo flag", {31'd0, irq}, 32'd1);
    for (int i = 8; i < 16; i++) send_word(ow(i));
    bus_read(2'd0, d);
    check("R8 no overwrite at 16", {31'd0, d[17]}, 32'd0);
    send_word(ow(16));
    bus_read(2'd0, d);
    check("R8 overwrite flag on 17th", {31'd0, d[17]}, 32'd1);
    apply_cfg();
    bus_read(2'd0, d);
    check("R8 write 1 keeps overwrite", {31'd0, d[17]}, 32'd1);
    check("R9 write 1 keeps half flag", {31'd0, d[18]}, 32'd1);
    for (int i = 0; i < 16; i++) begin
      bus_read(2'd1, d);
      check("R8 stored words kept", d, ow(i));
    end
    bus_read(2'd0, d);
    check("R8 dropped word absent", {31'd0, d[16]}, 32'd0);
    bus_write(2'd0, 32'h0008_0000 | {20'd0, cfg});
    bus_read(2'd0, d);
    check("R8 write 0 clears overwrite", {31'd0, d[17]}, 32'd0);
    check("R9 write 0 clears half flag", {31'd0, d[18]}, 32'd0);
    check("R11 irq low after clear", {31'd0, irq}, 32'd0);
    cfg[6] = 1'b0; apply_cfg();
  endtask

  task automatic t_ptrclr();
    logic [31:0] d;
    send_word(32'hDEAD_BEEF);
    send_word(32'hCAFE_F00D);
    bus_write(2'd0, KEEP | 32'h0100_0000 | {20'd0, cfg});
    bus_read(2'd0, d);
    check("R12 pointer clear empties", {31'd0, d[16]}, 32'd0);
    check("R12 pointer clear reads 0", {31'd0, d[24]}, 32'd0);
    send_word(32'h0BAD_CAB1);
    bus_read(2'd1, d);
    check("R12 fresh data after clear", d, 32'h0BAD_CAB1);
  endtask

  task automatic t_hblank_src();
    logic [31:0] d;
    cfg[4] = 1'b1; cfg[7] = 1'b1;
    bus_write(2'd0, 32'h0006_0000 | {20'd0, cfg});
    vs_pulse();
    bus_read(2'd0, d);
    check("R10 vsync ignored with blank source", {31'd0, d[19]}, 32'd0);
    check("R11 irq low without sync flag", {31'd0, irq}, 32'd0);
    blank_on();
    bus_read(2'd0, d);
    check("R10 blank edge sets sync flag", {31'd0, d[19]}, 32'd1);
    check("R11 irq on sync flag", {31'd0, irq}, 32'd1);
    cfg[7] = 1'b0; apply_cfg();
    check("R11 masked sync flag", {31'd0, irq}, 32'd0);
    blank_off();
    cfg[4] = 1'b0;
    bus_write(2'd0, 32'h0006_0000 | {20'd0, cfg});
  endtask

  task automatic t_swrst();
    logic [31:0] d;
    cfg[6] = 1'b1;
    apply_cfg();
    send_word(32'h1357_9BDF);
    vs_pulse();
    bus_write(2'd0, KEEP | 32'h0200_0000 | {20'd0, cfg});
    bus_read(2'd0, d);
    check("R13 soft reset keeps config, clears rest", d, {20'd0, cfg});
    send_word(32'h2468_ACE0);
    bus_read(2'd0, d);
    check("R13 capture disarmed after soft reset", {31'd0, d[16]}, 32'd0);
    vs_pulse();
    send_word(32'h2468_ACE0);
    bus_read(2'd1, d);
    check("R13 capture resumes after vsync", d, 32'h2468_ACE0);
    cfg[6] = 1'b0;
    bus_write(2'd0, 32'h0006_0000 | {20'd0, cfg});
  endtask

  task automatic t_pol_edge();
    logic [31:0] d;
    cfg[3:0] = 4'hF;
    bus_write(2'd0, 32'h0200_0000 | {20'd0, cfg});
    cam_vsync = 1'b0; cam_hsync = 1'b0; cam_hblank = 1'b0; cam_pclk = 1'b1;
    idle(4);
    send_word(32'h7777_7777);
    bus_read(2'd0, d);
    check("R3 active-high vsync needed", {31'd0, d[16]}, 32'd0);
    vs_pulse();
    send_word(32'h6666_6666);
    bus_read(2'd0, d);
    check("R3 active-high hsync gates", {31'd0, d[16]}, 32'd0);
    line_on();
    send_word(32'h5EC0_7A11);
    bus_read(2'd1, d);
    check("R4 falling edge capture", d, 32'h5EC0_7A11);
    blank_on();
    send_word(32'h4444_4444);
    bus_read(2'd0, d);
    check("R3 active-high blank gates", {31'd0, d[16]}, 32'd0);
    blank_off();
  endtask

  task automatic t_frame();
    cfg[11:8] = 4'd8; apply_cfg();
    check("R14 code 8", {21'd0, line_px}, 32'd352);
    cfg[11:8] = 4'd3; apply_cfg();
    check("R14 code 3", {21'd0, line_px}, 32'd640);
    cfg[11:8] = 4'd7; apply_cfg();
    check("R14 code 7", {21'd0, line_px}, 32'd176);
    cfg[11:8] = 4'd4; apply_cfg();
    check("R14 reserved code", {21'd0, line_px}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    cam_pclk = 1'b0; cam_vsync = 1'b1; cam_hsync = 1'b1; cam_hblank = 1'b1;
    cam_data = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_gating();
    t_bytemode();
    t_overflow();
    t_ptrclr();
    t_hblank_src();
    t_swrst();
    t_pol_edge();
    t_frame();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (R1..): got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule